// File: doc/BRIEF.md
# Multi-line receive merge buffer

This block gathers characters arriving from several serial line receivers into a single first-in, first-out buffer that a host drains one word at a time. Every stored entry remembers which line it came from and the error conditions seen with that character, so the host can service all lines through a single register without polling each receiver separately.

The host reads the buffer register repeatedly; each read removes the oldest entry and returns it with a valid marker set. A read that returns the valid marker clear means the buffer is drained. A control/status register exposes the receive-done condition, an interrupt enable and a self-clearing buffer-clear command, and a line configuration register switches reception on or off per line. Character loss on a full buffer is reported on the next character that line manages to store. A break reaches the host as a null character carrying a framing error; there is no dedicated break flag.

Top module: `rx_merge_buffer`

## Requirements
- R1: A buffer read (address 1) of a stored entry returns bit 15 = 1 (valid), bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 9:8 = source line number, bits 7:0 = character; bits 11:10 read as 0. Read data appears on `regRdata` on the clock edge that samples `regRd`.
- R2: A buffer read while the buffer is empty returns 16'h0000 and removes nothing.
- R3: Entries leave the buffer in arrival order; when several lines push in the same cycle, the lower-numbered line is stored first.
- R4: Control/status register (address 0) bit 0 (receive done) reads 1 exactly when the buffer holds at least one entry.
- R5: `irq` is high only while the buffer is non-empty and control/status bit 6 (receive interrupt enable, read/write) is 1.
- R6: Writing control/status bit 4 = 1 starts a clear that lasts CLEAR_CYCLES cycles; bit 4 reads 1 while it runs and 0 afterwards, and the buffer is empty when it ends. Pushes during a clear are discarded.
- R7: A push that finds no free space (free space is measured before a same-cycle pop) is dropped and the next entry stored from that line carries overrun = 1; the entry after that carries overrun = 0 unless another loss occurred.
- R8: A write to the line configuration register (address 2) sets the receive enable of line `regWdata[1:0]` to `regWdata[8]`; pushes from a line whose enable is 0 are ignored. All enables are 0 after reset.
- R9: A null character with a framing error is stored unchanged (character 8'h00, framing bit set) as the break indication.
- R10: The buffer stores DEPTH (64) entries; the 65th pending entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | NUM_LINES | Per-line character-ready strobe |
| rxChar | input | NUM_LINES*CHAR_W | Per-line received character, line k at bits k*CHAR_W upward |
| rxFrameErr | input | NUM_LINES | Per-line framing error with the character |
| rxParityErr | input | NUM_LINES | Per-line parity error with the character |
| regAddr | input | 2 | Register select: 0 control/status, 1 buffer, 2 line configuration |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a buffer read pops) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Registered read data |
| irq | output | 1 | Receive interrupt |

## Verification
Single pushes on one line establish the word layout and the break encoding, while four-line simultaneous pushes with distinct characters separate correct arbitration order from any other ordering. Filling the buffer with sixty-four entries and then pushing on every line distinguishes a correct capacity limit and per-line overrun carry from off-by-one depth or lost flags. A long pseudo-random phase mixes pushes, pops, overflow and enable changes against a bench queue model, exposing ordering, pointer-wrap and same-cycle push/pop interactions that the directed cases do not reach.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  // Register addresses
  localparam logic [1:0] REG_CSR  = 2'd0;
  localparam logic [1:0] REG_BUF  = 2'd1;
  localparam logic [1:0] REG_LCFG = 2'd2;

  // Control/status bit positions
  localparam int CSR_DONE_BIT = 0;
  localparam int CSR_CLR_BIT  = 4;
  localparam int CSR_IE_BIT   = 6;

  // Line configuration enable bit
  localparam int LCFG_EN_BIT = 8;

  // Buffer word bit positions
  localparam int BUF_VALID_BIT = 15;
  localparam int BUF_OVR_BIT   = 14;
  localparam int BUF_FE_BIT    = 13;
  localparam int BUF_PE_BIT    = 12;

  // Strobes from control to datapath
  typedef struct packed {
    logic pop;
    logic clearing;
  } rxmbStrobes_t;
endpackage

// File: rtl/rxmb_dpath.sv
module rxmb_dpath
  import rxmb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int CHAR_W    = 8,
  parameter int DEPTH     = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rxmbStrobes_t                  strobes,
  input  logic [NUM_LINES-1:0]          acceptMask,
  input  logic [NUM_LINES*CHAR_W-1:0]   rxChar,
  input  logic [NUM_LINES-1:0]          rxFrameErr,
  input  logic [NUM_LINES-1:0]          rxParityErr,
  output logic                          bufEmpty,
  output logic [15:0]                   headWord
);
  localparam int LINE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int ENTRY_W = 3 + LINE_W + CHAR_W;

  logic [ENTRY_W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [CNT_W-1:0]     count;
  logic [NUM_LINES-1:0] ovfPend, nextPend;
  logic [CNT_W-1:0]     slotsUsed, freeSlots;

  logic                 wrEn   [NUM_LINES];
  logic [PTR_W-1:0]     wrIdx  [NUM_LINES];
  logic [ENTRY_W-1:0]   wrWord [NUM_LINES];

  // Arbitration: lower line number takes the earlier slot
  always_comb begin
    logic [CNT_W-1:0] slots;
    slots     = '0;
    freeSlots = CNT_W'(DEPTH) - count;
    nextPend  = ovfPend;
    for (int k = 0; k < NUM_LINES; k++) begin
      wrEn[k]   = 1'b0;
      wrIdx[k]  = wrPtr + slots[PTR_W-1:0];
      wrWord[k] = {ovfPend[k], rxFrameErr[k], rxParityErr[k], LINE_W'(k),
                   rxChar[k*CHAR_W +: CHAR_W]};
      if (acceptMask[k] && !strobes.clearing) begin
        if (slots < freeSlots) begin
          wrEn[k]     = 1'b1;
          slots       = slots + CNT_W'(1);
          nextPend[k] = 1'b0;
        end else begin
          nextPend[k] = 1'b1;
        end
      end
    end
    slotsUsed = slots;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_LINES; k++) begin
      if (wrEn[k]) mem[wrIdx[k]] <= wrWord[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearing) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      ovfPend <= '0;
    end else begin
      wrPtr   <= wrPtr + slotsUsed[PTR_W-1:0];
      rdPtr   <= rdPtr + PTR_W'(strobes.pop);
      count   <= count + slotsUsed - CNT_W'(strobes.pop);
      ovfPend <= nextPend;
    end
  end

  assign bufEmpty = (count == '0);

  always_comb begin
    logic [ENTRY_W-1:0] e;
    e = mem[rdPtr];
    headWord = '0;
    headWord[BUF_VALID_BIT] = 1'b1;
    headWord[BUF_OVR_BIT]   = e[ENTRY_W-1];
    headWord[BUF_FE_BIT]    = e[ENTRY_W-2];
    headWord[BUF_PE_BIT]    = e[ENTRY_W-3];
    headWord[CHAR_W +: LINE_W] = e[CHAR_W +: LINE_W];
    headWord[CHAR_W-1:0]    = e[CHAR_W-1:0];
  end

  // R10: occupancy never exceeds capacity
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2: control never pops an empty buffer
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (count != '0));

  // R6: a clear cycle leaves the buffer empty
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearing |=> (count == '0));

  // R7: a push against a full buffer leaves that line flagged
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_ovfChk
    a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
      (acceptMask[k] && !strobes.clearing && count == CNT_W'(DEPTH)) |=> ovfPend[k]);
  end
endmodule

// File: rtl/rxmb_ctrl.sv
module rxmb_ctrl
  import rxmb_pkg::*;
#(
  parameter int NUM_LINES    = 4,
  parameter int CLEAR_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [15:0]          regWdata,
  input  logic [NUM_LINES-1:0] rxPush,
  input  logic                 bufEmpty,
  input  logic [15:0]          headWord,
  output rxmbStrobes_t         strobes,
  output logic [NUM_LINES-1:0] acceptMask,
  output logic [15:0]          regRdata,
  output logic                 irq
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CLR_W  = $clog2(CLEAR_CYCLES + 1);

  logic [NUM_LINES-1:0] lineEn;
  logic                 intEn;
  logic [CLR_W-1:0]     clrCnt;
  logic                 clearing;
  logic [15:0]          csrWord;
  logic                 unusedWdata;

  assign unusedWdata = ^regWdata;
  assign clearing    = (clrCnt != '0);

  assign strobes.clearing = clearing;
  assign strobes.pop      = regRd && (regAddr == REG_BUF) && !bufEmpty && !clearing;
  assign acceptMask       = rxPush & lineEn;
  assign irq              = !bufEmpty && intEn;

  always_comb begin
    csrWord = '0;
    csrWord[CSR_DONE_BIT] = !bufEmpty;
    csrWord[CSR_CLR_BIT]  = clearing;
    csrWord[CSR_IE_BIT]   = intEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineEn   <= '0;
      intEn    <= 1'b0;
      clrCnt   <= '0;
      regRdata <= '0;
    end else begin
      if (clearing) clrCnt <= clrCnt - CLR_W'(1);
      if (regWr && regAddr == REG_CSR) begin
        intEn <= regWdata[CSR_IE_BIT];
        if (regWdata[CSR_CLR_BIT]) clrCnt <= CLR_W'(CLEAR_CYCLES);
      end
      if (regWr && regAddr == REG_LCFG) begin
        if (int'(regWdata[LINE_W-1:0]) < NUM_LINES)
          lineEn[regWdata[LINE_W-1:0]] <= regWdata[LCFG_EN_BIT];
      end
      if (regRd) begin
        case (regAddr)
          REG_CSR: regRdata <= csrWord;
          REG_BUF: regRdata <= strobes.pop ? headWord : 16'h0000;
          default: regRdata <= 16'h0000;
        endcase
      end
    end
  end

  // R6: a clear command is reported busy on the next cycle
  a_r6_clear_starts: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == REG_CSR && regWdata[CSR_CLR_BIT]) |=> clearing);

  // R2: an empty buffer read returns all zeros
  a_r2_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == REG_BUF && bufEmpty) |=> (regRdata == 16'h0000));
endmodule

// File: rtl/rx_merge_buffer.sv
module rx_merge_buffer
  import rxmb_pkg::*;
#(
  parameter int NUM_LINES    = 4,
  parameter int CHAR_W       = 8,
  parameter int DEPTH        = 64,
  parameter int CLEAR_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        rxPush,
  input  logic [NUM_LINES*CHAR_W-1:0] rxChar,
  input  logic [NUM_LINES-1:0]        rxFrameErr,
  input  logic [NUM_LINES-1:0]        rxParityErr,
  input  logic [1:0]                  regAddr,
  input  logic                        regWr,
  input  logic                        regRd,
  input  logic [15:0]                 regWdata,
  output logic [15:0]                 regRdata,
  output logic                        irq
);
  rxmbStrobes_t         strobes;
  logic [NUM_LINES-1:0] acceptMask;
  logic                 bufEmpty;
  logic [15:0]          headWord;

  rxmb_ctrl #(
    .NUM_LINES(NUM_LINES), .CLEAR_CYCLES(CLEAR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .rxPush(rxPush), .bufEmpty(bufEmpty), .headWord(headWord),
    .strobes(strobes), .acceptMask(acceptMask),
    .regRdata(regRdata), .irq(irq)
  );

  rxmb_dpath #(
    .NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W), .DEPTH(DEPTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .acceptMask(acceptMask),
    .rxChar(rxChar), .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .bufEmpty(bufEmpty), .headWord(headWord)
  );

  // R5: interrupt only with data present
  a_r5_irq_has_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !bufEmpty);
endmodule

// File: tb/sim_rx_merge_buffer.sv
module sim_rx_merge_buffer;
  localparam int NL = 4, DEPTH = 64, CLRC = 4;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [3:0]  rxPush = '0, rxFrameErr = '0, rxParityErr = '0;
  logic [31:0] rxChar = '0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq;

  rx_merge_buffer #(.NUM_LINES(NL), .CHAR_W(8), .DEPTH(DEPTH), .CLEAR_CYCLES(CLRC)) u0 (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxChar(rxChar),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, seed = 32'h5eed;
  logic [15:0] q[$];
  bit pend[4], en[4], ie = 0;
  int clrLeft = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(int k, logic [7:0] ch, bit fe, bit pe, bit ovr);
    return {1'b1, ovr, fe, pe, 2'b00, 2'(k), ch};
  endfunction

  task automatic setPush(int k, logic [7:0] ch, bit fe, bit pe);
    rxPush[k] = 1'b1; rxChar[k*8 +: 8] = ch; rxFrameErr[k] = fe; rxParityErr[k] = pe;
  endtask

  // One cycle with the pushes already placed; optional buffer read
  task automatic cycle(bit doRead);
    logic [15:0] expRd;
    int freeSlots;
    bit busy;
    busy = clrLeft > 0;
    expRd = 16'h0;
    freeSlots = DEPTH - q.size();
    if (doRead && !busy && q.size() > 0) expRd = q.pop_front();
    if (!busy)
      for (int k = 0; k < NL; k++)
        if (rxPush[k] && en[k]) begin
          if (freeSlots > 0) begin
            q.push_back(mkWord(k, rxChar[k*8 +: 8], rxFrameErr[k], rxParityErr[k], pend[k]));
            pend[k] = 0; freeSlots--;
          end else pend[k] = 1;
        end
    regAddr = 2'd1; regRd = doRead;
    @(posedge clk);
    if (clrLeft > 0) clrLeft--;
    @(negedge clk);
    if (doRead) check("R1/R3 buffer word", regRdata, expRd);
    check("R5 irq", {15'b0, irq}, {15'b0, ie && q.size() > 0});
    rxPush = '0; rxFrameErr = '0; rxParityErr = '0; regRd = 1'b0;
  endtask

  task automatic wrReg(logic [1:0] a, logic [15:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk);
    if (clrLeft > 0) clrLeft--;
    if (a == 2'd0) begin
      ie = d[6];
      if (d[4]) begin clrLeft = CLRC; q.delete(); foreach (pend[i]) pend[i] = 0; end
    end
    if (a == 2'd2) en[d[1:0]] = d[8];
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdCsr(string req);
    logic [15:0] exp, mask;
    exp = '0;
    exp[0] = q.size() != 0; exp[4] = clrLeft > 0; exp[6] = ie;
    mask = (clrLeft > 0) ? 16'h0050 : 16'hFFFF;
    regAddr = 2'd0; regRd = 1'b1;
    @(posedge clk);
    if (clrLeft > 0) clrLeft--;
    @(negedge clk);
    regRd = 1'b0;
    check(req, regRdata & mask, exp & mask);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R2 reset read data", regRdata, 16'h0);
    check("R5 reset irq", {15'b0, irq}, 16'h0);
    cycle(1);                                  // R2 empty read returns zero
    rdCsr("R4 done clear when empty");

    setPush(1, 8'h33, 0, 0); cycle(0);         // R8 disabled line ignored
    cycle(1);
    rdCsr("R8 disabled line stored nothing");

    for (int k = 0; k < NL; k++) wrReg(2'd2, 16'h0100 | 16'(k));
    setPush(2, 8'h5A, 0, 1); cycle(0);
    rdCsr("R4 done set when non-empty");
    cycle(1);                                  // R1 layout
    check("R1 literal word", regRdata, 16'h925A);

    for (int k = 0; k < NL; k++) setPush(k, 8'hA0 + 8'(k), 0, 0);
    cycle(0);
    for (int k = 0; k < NL; k++) begin         // R3 lower line first
      cycle(1);
      check("R3 same-cycle order line", {14'b0, regRdata[9:8]}, 16'(k));
    end

    setPush(3, 8'h00, 1, 0); cycle(0); cycle(1);
    check("R9 break literal", regRdata, 16'hA300);

    setPush(0, 8'h42, 0, 0); cycle(0);
    check("R5 irq masked", {15'b0, irq}, 16'h0);
    wrReg(2'd0, 16'h0040);
    check("R5 irq raised", {15'b0, irq}, 16'h1);
    cycle(1);
    check("R5 irq dropped after drain", {15'b0, irq}, 16'h0);
    wrReg(2'd0, 16'h0000);

    // R10 capacity and R7 overrun
    for (int c = 0; c < 17; c++) begin
      for (int k = 0; k < NL; k++) setPush(k, 8'(c * 4 + k), 0, 0);
      cycle(0);
    end
    check("R10 stored count", 16'(q.size()), 16'd64);
    for (int i = 0; i < DEPTH; i++) cycle(1);
    cycle(1);
    check("R10 65th read empty", regRdata, 16'h0);
    setPush(1, 8'h11, 0, 0); cycle(0); cycle(1);
    check("R7 overrun on next entry", {15'b0, regRdata[14]}, 16'h1);
    setPush(1, 8'h12, 0, 0); cycle(0); cycle(1);
    check("R7 overrun cleared after", {15'b0, regRdata[14]}, 16'h0);

    // R6 clear
    setPush(2, 8'h77, 0, 0); setPush(3, 8'h78, 0, 0); cycle(0);
    wrReg(2'd0, 16'h0010);
    rdCsr("R6 clear busy");
    for (int i = 0; i < 6; i++) cycle(0);
    rdCsr("R6 clear finished");
    cycle(1);
    check("R6 buffer empty after clear", regRdata, 16'h0);

    // Random phase
    wrReg(2'd0, 16'h0040);
    for (int i = 0; i < 4000; i++) begin
      if (($random(seed) & 63) == 0)
        wrReg(2'd2, 16'(($random(seed) & 3) | ((($random(seed) & 3) != 0) ? 16'h0100 : 16'h0)));
      for (int k = 0; k < NL; k++)
        if (($random(seed) & 3) != 0)
          setPush(k, 8'($random(seed)), 1'($random(seed) & 1), 1'($random(seed) & 1));
      cycle((($random(seed) & 7) < 5));
    end
    while (q.size() > 0) cycle(1);
    cycle(1);
    check("R2 final empty read", regRdata, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule